// File: doc/BRIEF.md
# Trace-Driven Control-Flow Integrity Verifier

This block watches a processor from the outside. It reads the already-decoded stream of control-flow transfer events that comes out of the trace port, and it confirms that each transfer is one that static analysis of the program said could occur at that point. The core, its compiler and its instruction set stay unchanged. Each event gives the address of the transfer instruction, its instruction word and whether it was taken.

The expected program behaviour is held in an external metadata RAM, which is filled before the program starts. Each word describes one transfer instruction: where it lives, what its encoding must be, what kind of transfer it is, and which words may describe the next transfer. The verifier starts at word 0. For each accepted event it compares the event with the current word. If they agree, it moves to the successor word that the transfer kind and outcome select. The first disagreement raises an alarm that stays set, and the verifier stops accepting events. A skipped call, return or branch shows up as an address that does not match. A corrupted transfer instruction shows up as an instruction word that does not match.

Returns are resolved through a small internal stack of word indexes. A call pushes the index of the word to resume at, and a return pops it. The RAM has one cycle of read latency, so the event interface has a one-cycle gap after every accepted event.

Top module: `cfi_trace_verifier`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `ev_ready` is 0, `alarm` is 0 and `meta_raddr` is 0. `ev_ready` is 1 from the second cycle after reset.
- R2: An event whose address and instruction word equal those of the current metadata word is accepted without alarm. `ev_ready` is 0 in the cycle after an acceptance and 1 again in the cycle after that.
- R3: An accepted event whose address differs from the current word sets `alarm` from the next cycle. `alarm` then stays 1 and `ev_ready` stays 0 until reset.
- R4: An accepted event whose instruction word differs from the current word sets `alarm` in the same way as R3.
- R5: Metadata word layout: address in bits [95:64], instruction word in [63:32], field A in [31:16] and field B in [15:0]. Bits [31:30] hold the transfer kind (0 conditional, 1 jump, 2 call, 3 return). The successor index in field A is bits [29:16], zero-extended to 16 bits.
- R6: For a conditional kind, the next `meta_raddr` is the field-A index when the taken flag is 1 and field B when it is 0.
- R7: For a jump kind, the next `meta_raddr` is the field-A index whatever the taken flag.
- R8: A call moves to the field-A index and pushes field B. A return moves to the most recently pushed index that has not yet been popped (last-in, first-out across nested calls).
- R9: A matching return accepted while the index stack is empty sets `alarm`.
- R10: A matching call accepted while the stack already holds `STACK_DEPTH` (default 4) indexes sets `alarm`. Exactly `STACK_DEPTH` nested calls are accepted without alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | A decoded transfer event is offered |
| ev_ready | output | 1 | The verifier accepts the offered event this cycle |
| ev_addr | input | 32 | Address of the transfer instruction |
| ev_insn | input | 32 | Instruction word of the transfer instruction |
| ev_taken | input | 1 | Branch outcome, 1 when taken |
| meta_raddr | output | 16 | Index of the metadata word being read |
| meta_rdata | input | 96 | Metadata word, valid one cycle after `meta_raddr` |
| alarm | output | 1 | Sticky control-flow violation flag |

## Verification
The bench sends the same conditional word both ways. A design that swapped the two successor fields, or read the kind tag as part of the index, would jump to the wrong word. The nested call test returns through two levels, so a stack that popped in first-in, first-out order would resume at the outer site first. The stack edges are covered by a return with nothing pushed and by one call more than the depth. A design with an off-by-one full test would either alarm on a legal fourth call or let the fifth through. After an address or encoding mismatch the bench keeps offering events and checks that `alarm` holds and nothing more is accepted. A verifier that recovered, or that skipped the read gap after an acceptance, would show `ev_ready` high when it should be low.

// File: rtl/cfi_trace_pkg.sv
// Shared types for the trace-driven control-flow verifier.
// Assumes the fixed 96-bit metadata word layout described in the brief.
package cfi_trace_pkg;

    localparam int ADDR_W  = 32;
    localparam int INSN_W  = 32;
    localparam int IDX_W   = 16;
    localparam int KIND_W  = 2;
    localparam int ENTRY_W = ADDR_W + INSN_W + 2 * IDX_W;

    typedef enum logic [KIND_W-1:0] {
        XFER_COND = 2'd0,
        XFER_JUMP = 2'd1,
        XFER_CALL = 2'd2,
        XFER_RET  = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [INSN_W-1:0] insn;
        logic [IDX_W-1:0]  fld_a;
        logic [IDX_W-1:0]  fld_b;
    } meta_word_t;

    typedef enum logic [1:0] {
        VS_LOAD = 2'd0,
        VS_WAIT = 2'd1,
        VS_HALT = 2'd2
    } vstate_e;

endpackage

// File: rtl/cfi_ret_stack.sv
// LIFO of metadata indexes used to resolve return targets.
// Assumes DEPTH is a power of two; push and pop are never requested together.
// Callers must not push when full or pop when empty.
module cfi_ret_stack #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_val,
    output logic [WIDTH-1:0] top_val,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [CW-1:0]    cnt;
    logic [PW-1:0]    top_ptr;
    logic [PW-1:0]    wr_ptr;

    // Pointers into the slot array derived from the fill count.
    always_comb begin
        top_ptr = PW'(cnt - 1'b1);
        wr_ptr  = PW'(cnt);
    end

    // Fill count tracks pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push)
            cnt <= cnt + 1'b1;
        else if (pop)
            cnt <= cnt - 1'b1;
    end

    // Slot storage is written only on push.
    always_ff @(posedge clk) begin
        if (push)
            slots[wr_ptr] <= push_val;
    end

    // Status and the value a return would resume at.
    always_comb begin
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        top_val = slots[top_ptr];
    end

endmodule

// File: rtl/cfi_entry_match.sv
// Compares one trace event with the current metadata word and picks the
// successor index by transfer kind and outcome. Purely combinational.
// Assumes the stack status inputs reflect the state before this event.
module cfi_entry_match
    import cfi_trace_pkg::*;
(
    input  meta_word_t         word,
    input  logic [ADDR_W-1:0]  ev_addr,
    input  logic [INSN_W-1:0]  ev_insn,
    input  logic               ev_taken,
    input  logic [IDX_W-1:0]   stk_top,
    input  logic               stk_empty,
    input  logic               stk_full,
    output logic               fault,
    output logic [IDX_W-1:0]   nxt_idx,
    output logic               do_push,
    output logic               do_pop
);
    localparam int AIDX_W = IDX_W - KIND_W;

    xfer_kind_e        kind;
    logic [IDX_W-1:0]  a_idx;
    logic              mismatch;

    // Split field A into kind tag and zero-extended successor index.
    always_comb begin
        kind  = xfer_kind_e'(word.fld_a[IDX_W-1 -: KIND_W]);
        a_idx = {{KIND_W{1'b0}}, word.fld_a[AIDX_W-1:0]};
    end

    // Event identity check against the expected transfer instruction.
    always_comb begin
        mismatch = (ev_addr != word.addr) || (ev_insn != word.insn);
    end

    // Successor selection, stack requests and fault decision.
    always_comb begin
        nxt_idx = a_idx;
        do_push = 1'b0;
        do_pop  = 1'b0;
        fault   = mismatch;
        unique case (kind)
            XFER_COND: nxt_idx = ev_taken ? a_idx : word.fld_b;
            XFER_JUMP: nxt_idx = a_idx;
            XFER_CALL: begin
                nxt_idx = a_idx;
                do_push = !mismatch && !stk_full;
                fault   = mismatch || stk_full;
            end
            XFER_RET: begin
                nxt_idx = stk_top;
                do_pop  = !mismatch && !stk_empty;
                fault   = mismatch || stk_empty;
            end
        endcase
    end

endmodule

// File: rtl/cfi_trace_verifier.sv
// Top of the trace-driven control-flow verifier. Walks an external metadata
// RAM (one-cycle read latency) one transfer event at a time and raises a
// sticky alarm on the first event that the table does not allow.
// Assumes the RAM content is stable while the verifier runs.
module cfi_trace_verifier
    import cfi_trace_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    output logic                ev_ready,
    input  logic [ADDR_W-1:0]   ev_addr,
    input  logic [INSN_W-1:0]   ev_insn,
    input  logic                ev_taken,
    output logic [IDX_W-1:0]    meta_raddr,
    input  logic [ENTRY_W-1:0]  meta_rdata,
    output logic                alarm
);
    vstate_e           state;
    logic [IDX_W-1:0]  cur_idx;
    logic              alarm_q;
    meta_word_t        word;
    logic              accept;
    logic              fault;
    logic [IDX_W-1:0]  nxt_idx;
    logic              want_push;
    logic              want_pop;
    logic [IDX_W-1:0]  stk_top;
    logic              stk_empty;
    logic              stk_full;

    // Handshake: ready only while the read data for cur_idx is valid.
    always_comb begin
        word     = meta_word_t'(meta_rdata);
        ev_ready = (state == VS_WAIT);
        accept   = ev_valid && ev_ready;
    end

    cfi_entry_match u_match (
        .word      (word),
        .ev_addr   (ev_addr),
        .ev_insn   (ev_insn),
        .ev_taken  (ev_taken),
        .stk_top   (stk_top),
        .stk_empty (stk_empty),
        .stk_full  (stk_full),
        .fault     (fault),
        .nxt_idx   (nxt_idx),
        .do_push   (want_push),
        .do_pop    (want_pop)
    );

    cfi_ret_stack #(
        .DEPTH (STACK_DEPTH),
        .WIDTH (IDX_W)
    ) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept && want_push),
        .pop      (accept && want_pop),
        .push_val (word.fld_b),
        .top_val  (stk_top),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    // Walk state: read gap after each acceptance, halt on the first fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= VS_LOAD;
            cur_idx <= '0;
            alarm_q <= 1'b0;
        end else begin
            unique case (state)
                VS_LOAD: state <= VS_WAIT;
                VS_WAIT: begin
                    if (accept) begin
                        if (fault) begin
                            alarm_q <= 1'b1;
                            state   <= VS_HALT;
                        end else begin
                            cur_idx <= nxt_idx;
                            state   <= VS_LOAD;
                        end
                    end
                end
                VS_HALT: state <= VS_HALT;
                default: state <= VS_HALT;
            endcase
        end
    end

    // Outputs driven straight from state.
    always_comb begin
        meta_raddr = cur_idx;
        alarm      = alarm_q;
    end

endmodule

// File: rtl/cfi_trace_verifier_chk.sv
// Protocol and alarm checks for the verifier, attached by bind.
module cfi_trace_verifier_chk
    import cfi_trace_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_ready,
    input logic [IDX_W-1:0]  meta_raddr,
    input logic              alarm
);
    // R2: one-cycle gap after each acceptance
    p_read_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_ready) |=> !ev_ready);

    // R2: the read index holds while waiting without an event
    p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ready && !ev_valid) |=> $stable(meta_raddr));

    // R3: alarm never clears once set
    p_alarm_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> alarm);

    // R3: a halted verifier accepts nothing
    p_halt_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> !ev_ready);

    // R4: alarm rises only as a result of an accepted event
    p_alarm_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(ev_valid && ev_ready));

    // R1: alarm is clear whenever reset is asserted on the clock
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!alarm && !ev_ready));

endmodule

bind cfi_trace_verifier cfi_trace_verifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_ready   (ev_ready),
    .meta_raddr (meta_raddr),
    .alarm      (alarm)
);

// File: tb/cfi_trace_verifier_test.sv
module cfi_trace_verifier_test;
    import cfi_trace_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                ev_valid = 1'b0;
    logic                ev_ready;
    logic [ADDR_W-1:0]   ev_addr = '0;
    logic [INSN_W-1:0]   ev_insn = '0;
    logic                ev_taken = 1'b0;
    logic [IDX_W-1:0]    meta_raddr;
    logic [ENTRY_W-1:0]  meta_rdata = '0;
    logic                alarm;

    logic [ENTRY_W-1:0]  mem [16];
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    cfi_trace_verifier uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_ready   (ev_ready),
        .ev_addr    (ev_addr),
        .ev_insn    (ev_insn),
        .ev_taken   (ev_taken),
        .meta_raddr (meta_raddr),
        .meta_rdata (meta_rdata),
        .alarm      (alarm)
    );

    // Metadata RAM model with one cycle of read latency
    always @(posedge clk) meta_rdata <= mem[meta_raddr[3:0]];

    function automatic logic [31:0] adr_of(int i);
        return 32'h0000_1000 + 32'(i) * 32'h10;
    endfunction

    function automatic logic [31:0] ins_of(int i);
        return 32'hA500_0000 | 32'(i);
    endfunction

    // Builds a word per the R5 layout
    function automatic logic [ENTRY_W-1:0] mk(int i, logic [1:0] kind, int a, int b);
        return {adr_of(i), ins_of(i), kind, 14'(a), 16'(b)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 16; i++) mem[i] = mk(i, 2'd1, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        ev_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait for ready, offer one event for one cycle, sample after the edge
    task automatic send(string req, logic [31:0] a, logic [31:0] w, logic tk);
        int guard = 0;
        while (!ev_ready && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        check({req, " ready before event"}, 32'(ev_ready), 32'd1);
        ev_valid = 1'b1;
        ev_addr  = a;
        ev_insn  = w;
        ev_taken = tk;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic send_ok(string req, int i, logic tk, int exp_next);
        send(req, adr_of(i), ins_of(i), tk);
        check({req, " gap"}, 32'(ev_ready), 32'd0);
        check({req, " alarm"}, 32'(alarm), 32'd0);
        check({req, " next index"}, 32'(meta_raddr), 32'(exp_next));
        @(negedge clk);
        check({req, " ready back"}, 32'(ev_ready), 32'd1);
    endtask

    task automatic expect_halt(string req);
        check({req, " alarm set"}, 32'(alarm), 32'd1);
        check({req, " ready low"}, 32'(ev_ready), 32'd0);
        ev_valid = 1'b1;
        repeat (5) @(negedge clk);
        ev_valid = 1'b0;
        check({req, " alarm held"}, 32'(alarm), 32'd1);
        check({req, " still halted"}, 32'(ev_ready), 32'd0);
    endtask

    task automatic t_reset_r1();
        clear_mem();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 ready in reset", 32'(ev_ready), 32'd0);
        check("R1 alarm in reset", 32'(alarm), 32'd0);
        rst_n = 1'b1;
        check("R1 first cycle ready", 32'(ev_ready), 32'd0);
        check("R1 start index", 32'(meta_raddr), 32'd0);
        @(negedge clk);
        check("R1 ready second cycle", 32'(ev_ready), 32'd1);
    endtask

    task automatic t_cond_r6();
        clear_mem();
        mem[0] = mk(0, 2'd0, 3, 5);
        do_reset();
        send_ok("R6 taken", 0, 1'b1, 3);
        do_reset();
        send_ok("R6 not taken", 0, 1'b0, 5);
    endtask

    task automatic t_jump_r7();
        clear_mem();
        mem[0] = mk(0, 2'd1, 7, 9);
        mem[7] = mk(7, 2'd1, 2, 11);
        do_reset();
        send_ok("R7 jump flag 0", 0, 1'b0, 7);
        send_ok("R7 jump flag 1", 7, 1'b1, 2);
    endtask

    task automatic t_calls_r8();
        clear_mem();
        mem[0] = mk(0, 2'd2, 1, 4);
        mem[1] = mk(1, 2'd2, 2, 6);
        mem[2] = mk(2, 2'd3, 0, 0);
        mem[6] = mk(6, 2'd3, 0, 0);
        mem[4] = mk(4, 2'd1, 8, 0);
        do_reset();
        send_ok("R8 outer call", 0, 1'b1, 1);
        send_ok("R8 inner call", 1, 1'b1, 2);
        send_ok("R8 inner return", 2, 1'b1, 6);
        send_ok("R8 outer return", 6, 1'b1, 4);
        send_ok("R2 chain continues", 4, 1'b1, 8);
    endtask

    task automatic t_bad_addr_r3();
        clear_mem();
        mem[0] = mk(0, 2'd1, 1, 0);
        do_reset();
        send("R3 skipped transfer", adr_of(1), ins_of(0), 1'b1);
        expect_halt("R3");
    endtask

    task automatic t_bad_insn_r4();
        clear_mem();
        mem[0] = mk(0, 2'd1, 1, 0);
        do_reset();
        send("R4 corrupted word", adr_of(0), ins_of(0) ^ 32'h0000_0100, 1'b1);
        expect_halt("R4");
    endtask

    task automatic t_underflow_r9();
        clear_mem();
        mem[0] = mk(0, 2'd3, 0, 0);
        do_reset();
        send("R9 empty return", adr_of(0), ins_of(0), 1'b1);
        expect_halt("R9");
    endtask

    task automatic t_overflow_r10();
        clear_mem();
        mem[0] = mk(0, 2'd2, 0, 1);
        do_reset();
        for (int k = 0; k < 4; k++) send_ok("R10 call within depth", 0, 1'b1, 0);
        send("R10 call beyond depth", adr_of(0), ins_of(0), 1'b1);
        expect_halt("R10");
    endtask

    // R5: the layout is exercised by every mk() word above
    initial begin
        t_reset_r1();
        t_cond_r6();
        t_jump_r7();
        t_calls_r8();
        t_bad_addr_r3();
        t_bad_insn_r4();
        t_underflow_r9();
        t_overflow_r10();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule